// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block guards an enclosure against being opened. A normally-closed switch holds the raw event input at the closed level (0). When the enclosure is opened, the input moves to the open level (1). The block synchronizes that input into its clock domain and filters it with a short debounce. When it sees a change from closed to open, it copies the running clock/calendar into a held timestamp record. In the same clock it raises an event flag and an interrupt request.

The capture is one-shot. After the first event, later events leave the held record alone. Software reads the record and then pulses a status-clear strobe, which re-arms the block. Capture only happens while the enable input is high. The debounce counts sample-tick pulses supplied from outside, so the filter window is set by the tick rate and by a parameter. A parameter value of zero removes the filter.

Top module: `tamper_ts_capture`

## Requirements
- R1: After reset, `evt_flag` and `irq` are 0 and every held timestamp field is 0.
- R2: The event input passes through two flip-flops. A changed level is accepted only after it has differed from the accepted level on `DEBOUNCE_TICKS` consecutive `sample_tick` pulses (default 3). A shorter excursion is discarded. A value of 0 accepts the synchronized level with no filtering.
- R3: An event is a change of the accepted level from closed (0) to open (1), with `OPEN_LEVEL` = 1. Staying open, or returning to closed, is not an event.
- R4: An event that arrives while `evt_en` is 1 and the flag is clear captures all six live fields from a single clock cycle. It also sets `evt_flag`.
- R5: While `evt_flag` is set, further events leave the held timestamp unchanged.
- R6: A one-cycle pulse on `stat_clr` clears `evt_flag` and re-arms capture. It leaves the held timestamp as it was.
- R7: If `stat_clr` falls in the same cycle as an event, the event is captured. The flag stays 1 and the held record takes the live time of that cycle.
- R8: While `evt_en` is 0, events are ignored. The held record and the flag do not change, and clearing `evt_en` does not erase a held timestamp.
- R9: Setting `evt_en` while the accepted level is already open does not cause a capture.
- R10: `irq` is 1 exactly when `evt_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Raw tamper input, 1 = open |
| sample_tick | input | 1 | Debounce sample strobe |
| evt_en | input | 1 | Event detection enable |
| stat_clr | input | 1 | Status-clear write strobe |
| live_sec | input | 6 | Running seconds |
| live_min | input | 6 | Running minutes |
| live_hour | input | 5 | Running hours |
| live_day | input | 5 | Running day of month |
| live_mon | input | 4 | Running month |
| live_year | input | 7 | Running year |
| ts_sec | output | 6 | Held seconds |
| ts_min | output | 6 | Held minutes |
| ts_hour | output | 5 | Held hours |
| ts_day | output | 5 | Held day |
| ts_mon | output | 4 | Held month |
| ts_year | output | 7 | Held year |
| evt_flag | output | 1 | Event status flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `stat_clr` and `sample_tick` are single-cycle strobes. They also assume that `evt_en` and the live time fields are driven synchronously to `clk`. The bench changes every input on the falling edge only, pulses each strobe for exactly one cycle, and leaves idle cycles between ticks. It changes the raw input only after the previous level has been either accepted or discarded.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;
  localparam int TS_W   = SEC_W + MIN_W + HOUR_W + DAY_W + MON_W + YEAR_W;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } tstamp_t;

  // Rising transition toward the open level of the accepted input.
  function automatic logic is_open_edge(logic now_lvl, logic prev_lvl, logic open_lvl);
    return (now_lvl == open_lvl) && (prev_lvl != open_lvl);
  endfunction
endpackage

// File: rtl/tts_sync.sv
module tts_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{IDLE_LVL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tts_debounce.sv
module tts_debounce #(
  parameter int unsigned TICKS    = 3,
  parameter logic        IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  generate
    if (TICKS == 0) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= IDLE_LVL;
        else        dout <= din;
      end
    end else begin : g_filt
      localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);
      logic [CW-1:0] cnt;

      function automatic logic window_done(logic [CW-1:0] c);
        return 32'(c) == TICKS - 1;
      endfunction

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt  <= '0;
          dout <= IDLE_LVL;
        end else if (din == dout) begin
          cnt <= '0;
        end else if (tick) begin
          if (window_done(cnt)) begin
            dout <= din;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tts_capture.sv
module tts_capture
  import tts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    open_edge,
  input  logic    enable,
  input  logic    clr,
  input  tstamp_t live,
  output tstamp_t held,
  output logic    flag,
  output logic    capture_ev
);
  // Armed when flag is low, or being cleared this very cycle.
  assign capture_ev = open_edge & enable & (~flag | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      flag <= 1'b0;
    end else if (capture_ev) begin
      held <= live;
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tamper_ts_capture.sv
module tamper_ts_capture
  import tts_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 3,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter logic        OPEN_LEVEL     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              sample_tick,
  input  logic              evt_en,
  input  logic              stat_clr,
  input  logic [SEC_W-1:0]  live_sec,
  input  logic [MIN_W-1:0]  live_min,
  input  logic [HOUR_W-1:0] live_hour,
  input  logic [DAY_W-1:0]  live_day,
  input  logic [MON_W-1:0]  live_mon,
  input  logic [YEAR_W-1:0] live_year,
  output logic [SEC_W-1:0]  ts_sec,
  output logic [MIN_W-1:0]  ts_min,
  output logic [HOUR_W-1:0] ts_hour,
  output logic [DAY_W-1:0]  ts_day,
  output logic [MON_W-1:0]  ts_mon,
  output logic [YEAR_W-1:0] ts_year,
  output logic              evt_flag,
  output logic              irq
);
  localparam logic IDLE_LEVEL = ~OPEN_LEVEL;

  // Named internal events, observed by the bound checker.
  logic    sync_lvl;
  logic    filt_lvl;
  logic    filt_q;
  logic    open_edge;
  logic    capture_ev;
  tstamp_t live_ts;
  tstamp_t held_ts;

  assign live_ts = '{year: live_year, mon: live_mon, day: live_day,
                     hour: live_hour, min: live_min, sec: live_sec};

  tts_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LEVEL)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(evt_in), .dout(sync_lvl)
  );

  tts_debounce #(.TICKS(DEBOUNCE_TICKS), .IDLE_LVL(IDLE_LEVEL)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .din(sync_lvl), .dout(filt_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= IDLE_LEVEL;
    else        filt_q <= filt_lvl;
  end

  assign open_edge = is_open_edge(filt_lvl, filt_q, OPEN_LEVEL);

  tts_capture u_cap (
    .clk(clk), .rst_n(rst_n), .open_edge(open_edge), .enable(evt_en),
    .clr(stat_clr), .live(live_ts), .held(held_ts), .flag(evt_flag),
    .capture_ev(capture_ev)
  );

  assign irq     = evt_flag;
  assign ts_sec  = held_ts.sec;
  assign ts_min  = held_ts.min;
  assign ts_hour = held_ts.hour;
  assign ts_day  = held_ts.day;
  assign ts_mon  = held_ts.mon;
  assign ts_year = held_ts.year;
endmodule

// File: rtl/tamper_ts_capture_chk.sv
module tamper_ts_capture_chk
  import tts_pkg::*;
#(
  parameter int unsigned TICKS = 3
) (
  input logic    clk,
  input logic    rst_n,
  input logic    sample_tick,
  input logic    evt_en,
  input logic    stat_clr,
  input logic    filt_lvl,
  input logic    capture_ev,
  input tstamp_t live,
  input tstamp_t held,
  input logic    evt_flag
);
  localparam logic FILTERED = (TICKS != 0);

  // R2: with filtering, the accepted level only moves on a sample tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (FILTERED && !sample_tick) |=> $stable(filt_lvl));

  // R4: the whole record comes from one cycle of live time
  a_r4_whole_record: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |=> (held == $past(live)) && evt_flag);

  // R5: a set flag holds both itself and the record until cleared
  a_r5_hold_while_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !stat_clr) |=> ($stable(held) && evt_flag));

  // R6: a clear without a coinciding capture drops the flag
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !capture_ev) |=> !evt_flag);

  // R8: with detection disabled the record is frozen
  a_r8_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |=> $stable(held));
endmodule

bind tamper_ts_capture tamper_ts_capture_chk #(.TICKS(DEBOUNCE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .evt_en(evt_en),
  .stat_clr(stat_clr), .filt_lvl(filt_lvl), .capture_ev(capture_ev),
  .live(live_ts), .held(held_ts), .evt_flag(evt_flag)
);

// File: tb/tamper_ts_capture_tb_top.sv
`timescale 1ns/1ps
module tamper_ts_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_in = 1'b0, sample_tick = 1'b0, evt_en = 1'b0, stat_clr = 1'b0;
  logic [5:0] live_sec = '0, live_min = '0;
  logic [4:0] live_hour = '0, live_day = '0;
  logic [3:0] live_mon = '0;
  logic [6:0] live_year = '0;
  logic [5:0] ts_sec, ts_min;
  logic [4:0] ts_hour, ts_day;
  logic [3:0] ts_mon;
  logic [6:0] ts_year;
  logic evt_flag, irq;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  tamper_ts_capture dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sample_tick(sample_tick),
    .evt_en(evt_en), .stat_clr(stat_clr),
    .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
    .live_day(live_day), .live_mon(live_mon), .live_year(live_year),
    .ts_sec(ts_sec), .ts_min(ts_min), .ts_hour(ts_hour),
    .ts_day(ts_day), .ts_mon(ts_mon), .ts_year(ts_year),
    .evt_flag(evt_flag), .irq(irq)
  );

  // Distinct time record per seed; seed 0 gives all zeros.
  function automatic logic [32:0] mk(int s);
    logic [6:0] y = 7'((s * 5) % 100);
    logic [3:0] mo = 4'(s % 12);
    logic [4:0] d = 5'((s * 3) % 31);
    logic [4:0] h = 5'(s % 24);
    logic [5:0] mi = 6'((s * 7) % 60);
    logic [5:0] se = 6'(s % 60);
    return {y, mo, d, h, mi, se};
  endfunction

  task automatic set_live(int s);
    {live_year, live_mon, live_day, live_hour, live_min, live_sec} = mk(s);
  endtask

  task automatic chk(string req, logic [32:0] got, logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_state(string req, logic ef, int es);
    chk(req, {32'd0, evt_flag}, {32'd0, ef});
    chk("R10", {32'd0, irq}, {32'd0, ef});
    chk(req, {ts_year, ts_mon, ts_day, ts_hour, ts_min, ts_sec}, mk(es));
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0; @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      sample_tick = 1'b1; @(negedge clk); sample_tick = 1'b0; @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic       clr;
    logic       en;
    logic       lvl;
    logic [1:0] nt;
    logic [7:0] seed;
    logic       ef;
    logic [7:0] es;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 2'd3, 8'd5,  1'b0, 8'd0},   // R3 closed: nothing
    '{1'b0, 1'b1, 1'b1, 2'd2, 8'd6,  1'b0, 8'd0},   // R2 short open
    '{1'b0, 1'b1, 1'b0, 2'd3, 8'd7,  1'b0, 8'd0},   // R2 back closed
    '{1'b0, 1'b1, 1'b1, 2'd3, 8'd9,  1'b1, 8'd9},   // R4 capture
    '{1'b0, 1'b1, 1'b0, 2'd3, 8'd10, 1'b1, 8'd9},   // R3 close: no event
    '{1'b0, 1'b1, 1'b1, 2'd3, 8'd11, 1'b1, 8'd9},   // R5 second event
    '{1'b0, 1'b1, 1'b0, 2'd3, 8'd12, 1'b1, 8'd9},
    '{1'b1, 1'b1, 1'b0, 2'd3, 8'd13, 1'b0, 8'd9},   // R6 clear keeps ts
    '{1'b0, 1'b1, 1'b1, 2'd3, 8'd20, 1'b1, 8'd20},  // R6 re-armed
    '{1'b1, 1'b0, 1'b0, 2'd3, 8'd21, 1'b0, 8'd20},
    '{1'b0, 1'b0, 1'b1, 2'd3, 8'd22, 1'b0, 8'd20},  // R8 disabled
    '{1'b0, 1'b1, 1'b1, 2'd3, 8'd23, 1'b0, 8'd20},  // R9 enable while open
    '{1'b0, 1'b1, 1'b0, 2'd3, 8'd24, 1'b0, 8'd20},
    '{1'b0, 1'b1, 1'b1, 2'd3, 8'd30, 1'b1, 8'd30},  // R4 capture again
    '{1'b0, 1'b0, 1'b0, 2'd3, 8'd31, 1'b1, 8'd30}   // R8 disable keeps
  };

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1", 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 1'b0, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].clr) pulse_clr();
      evt_en = VEC[v].en;
      set_live(int'(VEC[v].seed));
      evt_in = VEC[v].lvl;
      repeat (3) @(negedge clk);
      ticks(int'(VEC[v].nt));
      repeat (3) @(negedge clk);
      check_state($sformatf("vec%0d", v), VEC[v].ef, int'(VEC[v].es));
    end

    // R7 and R4: clear coincides with the event; live time moves in that cycle
    evt_en = 1'b1;
    set_live(50);
    evt_in = 1'b1;
    repeat (3) @(negedge clk);
    ticks(2);
    sample_tick = 1'b1; @(negedge clk);
    sample_tick = 1'b0; stat_clr = 1'b1; set_live(51);
    @(negedge clk);
    stat_clr = 1'b0; set_live(52);
    repeat (2) @(negedge clk);
    check_state("R7", 1'b1, 51);

    // R6: plain clear afterwards keeps the record
    pulse_clr();
    check_state("R6", 1'b0, 51);

    // R1: reset in mid-run wipes everything
    rst_n = 1'b0;
    @(negedge clk);
    check_state("R1", 1'b0, 0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule